// File: doc/BRIEF.md
# Receive Word Output Formatter

This block takes aligned 10-bit receive code groups from an upstream aligner and presents them on a parallel interface to the protocol layer. It also produces the two receive byte clocks as ordinary registered logic outputs. These clocks are built from an internal clock that runs `RATIO` times faster than the word rate. Two static select inputs choose one of three presentation modes:

- half-rate, with two alternating byte clocks;
- full-rate, with a single byte clock;
- a 5-bit double-data-rate mode.

The block pulls one word from the aligner per word period and signals that pull on `word_ld`. While a word is shown, its bit 0 stays on `rd[0]`, so the first bit received keeps the lowest position.

When the aligner raises `realign`, the block freezes its whole output state for one extra word period and then resumes the normal sequence. Because nothing is skipped, any clock level in progress is only lengthened. No high or low phase ever gets shorter, and no narrow pulse can appear.

Top module: `rx_word_fmt`

## Requirements
- R1: While `rst_n` is low, `rbc0`, `rbc1` and `rd` are all 0.
- R2: When no stretch is active and `realign` is low, `word_ld` is high in the last of every `RATIO` cycles. At that edge `din` is captured and becomes the shown word. `word_ld` is never high in two consecutive cycles.
- R3: With `ddr_sel`=0 and `clk_mode_sel`=1 (full rate), `rd` carries the whole shown word and `rbc1` is 0. `rbc0` is low for the first `RATIO/2` cycles of each word period and high for the rest, so it rises mid-word while `rd` is steady.
- R4: With `ddr_sel`=0 and `clk_mode_sel`=0 (half rate), the words loaded after reset are counted from 0. `rbc1` rises at the middle of even-numbered words and falls at the middle of odd-numbered words. `rbc0` is always the complement of `rbc1`, so each clock marks every other word.
- R5: With `ddr_sel`=1, `rd[9:5]` is 0. `rd[4:0]` carries word bits 4..0 during the first half of the word period and word bits 9..5 during the second half. `rbc0` is high from cycle `RATIO/4` to cycle `3*RATIO/4-1` of the period, so one edge falls mid-way through each half. `rbc1` is 0.
- R6: A high `realign` while no stretch is active starts a stretch that lasts `RATIO` cycles. During the stretch no word is loaded and `rbc0`, `rbc1` and `rd` stay unchanged. A high `realign` during a stretch is ignored. Afterwards the sequence resumes at the phase where it stopped.
- R7: In DDR mode, `clk_mode_sel` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, `RATIO` times the word rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_sel | input | 1 | 0: 10-bit interface, 1: 5-bit DDR interface |
| clk_mode_sel | input | 1 | With `ddr_sel`=0: 0 half-rate clocks, 1 full-rate clock |
| realign | input | 1 | Aligner request to stretch by one word period |
| din | input | DW | Aligned code group, bit 0 received first |
| word_ld | output | 1 | `din` is captured at the end of this cycle |
| rbc0 | output | 1 | Receive byte clock 0 |
| rbc1 | output | 1 | Receive byte clock 1 |
| rd | output | DW | Parallel receive data |

## Verification
The bench builds the block with `DW`=10 and `RATIO`=8. With that ratio the quarter-period edges of the DDR clock fall on distinct cycles, and every clock level lasts several cycles. A stretch can therefore be seen to lengthen a level that is already part way through.

Each mode runs in its own segment with random `realign` pulses, some of them two cycles long so that they land inside a stretch. In the final segment `clk_mode_sel` toggles at random while DDR is selected.

// File: rtl/rx_word_fmt.sv
module rx_word_fmt #(
  parameter int DW    = 10,
  parameter int RATIO = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ddr_sel,
  input  logic          clk_mode_sel,
  input  logic          realign,
  input  logic [DW-1:0] din,
  output logic          word_ld,
  output logic          rbc0,
  output logic          rbc1,
  output logic [DW-1:0] rd
);
  localparam int PW   = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam int HALF = RATIO / 2;
  localparam int QTR  = RATIO / 4;
  localparam int HW   = DW / 2;

  logic [PW-1:0] phase, phase_n, hold;
  logic          odd, odd_n;
  logic [DW-1:0] word, word_n;

  wire advance = (hold == '0) && !realign;
  wire wrap    = (phase == PW'(RATIO - 1));

  assign word_ld = advance && wrap;

  always_comb begin
    phase_n = phase;
    odd_n   = odd;
    word_n  = word;
    if (advance) begin
      phase_n = wrap ? '0 : phase + 1'b1;
      if (wrap) begin
        odd_n  = ~odd;
        word_n = din;
      end
    end
  end

  wire lo_half  = (phase_n < PW'(HALF));
  wire half_clk = odd_n ? lo_half : !lo_half;
  wire ddr_clk  = (phase_n >= PW'(QTR)) && (phase_n < PW'(QTR + HALF));
  wire half_md  = !ddr_sel && !clk_mode_sel;

  wire          rbc0_n = ddr_sel ? ddr_clk : (clk_mode_sel ? !lo_half : !half_clk);
  wire          rbc1_n = half_md && half_clk;
  wire [DW-1:0] rd_n   = ddr_sel
                       ? {{(DW-HW){1'b0}}, (lo_half ? word_n[HW-1:0] : word_n[DW-1:HW])}
                       : word_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      odd   <= 1'b1;
      word  <= '0;
      hold  <= '0;
      rbc0  <= 1'b0;
      rbc1  <= 1'b0;
      rd    <= '0;
    end else begin
      phase <= phase_n;
      odd   <= odd_n;
      word  <= word_n;
      if (hold != '0)  hold <= hold - 1'b1;
      else if (realign) hold <= PW'(RATIO - 1);
      rbc0  <= rbc0_n;
      rbc1  <= rbc1_n;
      rd    <= rd_n;
    end
  end
endmodule

// File: rtl/rx_word_fmt_chk.sv
module rx_word_fmt_chk #(
  parameter int DW    = 10,
  parameter int RATIO = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ddr_sel,
  input logic          clk_mode_sel,
  input logic          realign,
  input logic          word_ld,
  input logic          rbc0,
  input logic          rbc1,
  input logic [DW-1:0] rd,
  input logic [((RATIO > 1) ? $clog2(RATIO) : 1)-1:0] hold
);
  localparam int HW = DW / 2;

  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    word_ld |=> !word_ld); // R2
  AST_RBC1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_sel || clk_mode_sel) |=> !rbc1); // R3
  AST_HALF_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ddr_sel && !clk_mode_sel) |=> (rbc0 != rbc1)); // R4
  AST_DDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_sel |=> (rd[DW-1:HW] == '0)); // R5
  AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && (hold != '0 || realign) && $stable(ddr_sel) && $stable(clk_mode_sel))
      |=> ($stable(rbc0) && $stable(rbc1) && $stable(rd))); // R6
  AST_STRETCH_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0) |-> !word_ld); // R6
endmodule

bind rx_word_fmt rx_word_fmt_chk #(.DW(DW), .RATIO(RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .ddr_sel(ddr_sel), .clk_mode_sel(clk_mode_sel),
  .realign(realign), .word_ld(word_ld), .rbc0(rbc0), .rbc1(rbc1), .rd(rd),
  .hold(hold)
);

// File: tb/rx_word_fmt_test.sv
`timescale 1ns/1ps
module rx_word_fmt_test;
  localparam int DW = 10;
  localparam int R  = 8;

  logic clk = 1'b0, rst_n = 1'b0, ddr_sel = 1'b0, clk_mode_sel = 1'b0, realign = 1'b0;
  logic [DW-1:0] din = '0;
  logic word_ld, rbc0, rbc1;
  logic [DW-1:0] rd;

  rx_word_fmt #(.DW(DW), .RATIO(R)) uut (
    .clk(clk), .rst_n(rst_n), .ddr_sel(ddr_sel), .clk_mode_sel(clk_mode_sel),
    .realign(realign), .din(din), .word_ld(word_ld), .rbc0(rbc0), .rbc1(rbc1), .rd(rd)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model: cycle within word, count of loaded words, stretch left
  int m_cyc, m_loaded, m_stretch, m_wcount;
  bit m_live;
  logic [DW-1:0] m_word;

  function automatic logic [DW-1:0] gen_word(int n);
    return DW'((n * 379 + 83) ^ (n << 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_loaded = 0; m_stretch = 0; m_live = 0; m_word = '0; m_wcount = 0;
    end else begin
      m_live = 1;
      if (m_stretch > 0) m_stretch--;
      else if (realign) m_stretch = R - 1;
      else if (m_cyc == R - 1) begin
        m_cyc = 0; m_word = din; m_loaded++; m_wcount++;
      end else m_cyc++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(int mode);
    int e0, e1, erd, pos;
    string t;
    t = (mode == 0) ? "R3" : (mode == 1) ? "R4" : (mode == 2) ? "R5" : "R7";
    if (!m_live) begin e0 = 0; e1 = 0; erd = 0; end
    else if (mode == 0) begin
      e0 = (m_cyc >= R/2); e1 = 0; erd = m_word;
    end else if (mode == 1) begin
      // word 1 is the first loaded (even) word; two-word cycle position
      pos = ((m_loaded % 2 == 1) ? 0 : R) + m_cyc;
      e1 = (pos >= R/2 && pos < R/2 + R);
      e0 = !e1; erd = m_word;
    end else begin
      e0 = (m_cyc >= R/4 && m_cyc < 3*R/4); e1 = 0;
      erd = (m_cyc < R/2) ? m_word[4:0] : m_word[9:5];
    end
    if (m_stretch > 0) t = {t, "/R6"};
    chk(rbc0 === e0[0], {t, " rbc0"}, rbc0, e0);
    chk(rbc1 === e1[0], {t, " rbc1"}, rbc1, e1);
    chk(rd === DW'(erd), {t, " rd"}, rd, erd);
  endtask

  task automatic run_segment(int mode, int cycles);
    int rl;
    rst_n = 1'b0; realign = 1'b0;
    ddr_sel = (mode >= 2); clk_mode_sel = (mode == 0);
    repeat (3) @(negedge clk);
    chk(rbc0 === 1'b0 && rbc1 === 1'b0, "R1 clocks in reset", {rbc0, rbc1}, 0);
    chk(rd === '0, "R1 rd in reset", rd, 0);
    rst_n = 1'b1;
    rl = 0;
    din = gen_word(0);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outputs(mode);
      din = gen_word(m_wcount);
      if (rl > 0) rl--;
      else if ($urandom_range(0, 11) == 0) rl = $urandom_range(1, 2);
      realign = (rl > 0);
      if (mode == 3) clk_mode_sel = $urandom_range(0, 1); // R7 ignored select
      #1;
      chk(word_ld === (m_stretch == 0 && !realign && m_cyc == R - 1),
          (m_stretch > 0) ? "R6 word_ld" : "R2 word_ld", word_ld,
          (m_stretch == 0 && !realign && m_cyc == R - 1));
    end
  endtask

  initial begin
    run_segment(0, 300);
    run_segment(1, 300);
    run_segment(2, 300);
    run_segment(3, 300);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule